// File: doc/BRIEF.md
# AES-128 Round Key Generator

This block turns a 128-bit cipher key into the eleven 128-bit round keys used by a ten-round AES-128 encrypt or decrypt pipeline. It does not build the schedule in parallel logic. It produces one 32-bit schedule word per clock and stores each word in a register bank. Words 0 to 3 are the key itself. Words 4 to 43 are generated over forty consecutive cycles after reset is released.

To use it, the key is placed on `keyIn` and reset is pulsed. When reset drops, the generator runs without further input. A ready flag rises once the last word is stored, and the data pipeline waits for that flag. Round keys are read through an indexed port, so a decrypting pipeline simply reads the indices in descending order. A new key takes effect only through another reset.

Top module: `aesKeyExpand`

## Requirements
- R1: The round key at index 0 equals the key held on `keyIn` while reset was asserted. Schedule word 0 is `keyIn[127:96]`. Round key r is presented on `rdKey` as {word 4r, 4r+1, 4r+2, 4r+3}, with the first word in bits 127:96.
- R2: After reset is released, `keyReady` stays 0 for the first 39 rising edges and is 1 after the 40th. One schedule word is stored per edge.
- R3: Once `keyReady` is 1, it stays 1 until reset is asserted again.
- R4: Asserting reset clears `keyReady` by the following cycle and restarts generation from the current `keyIn`. This holds even if an earlier generation had not finished. The new schedule replaces the old one completely.
- R5: A word whose index is not a multiple of 4 is the word four places earlier XOR the previous word.
- R6: A word whose index i is a multiple of 4 is w[i-4] XOR SubWord(RotWord(w[i-1])) XOR a round constant placed in the most significant byte. The constants follow the sequence 01, 02, 04, 08, 10, 20, 40, 80, 1B, 36. With key 2B7E151628AED2A6ABF7158809CF4F3C, round key 10 is D014F9A8C9EE2589E13F0CC8B6630CA6.
- R7: A read index greater than 10 returns all zeros on `rdKey`.
- R8: A change on `keyIn` while reset is low has no effect on the stored round keys.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; loads the key and restarts generation |
| keyIn | input | 128 | Cipher key, sampled while reset is high |
| rdIdx | input | 4 | Round key index, 0 to 10 |
| rdKey | output | 128 | Round key at `rdIdx` (combinational read) |
| keyReady | output | 1 | High once all 44 schedule words are stored |

## Verification
The schedule is exercised with four keys, and each one exposes a different kind of fault:

- **Standard test key.** Its published round keys 1, 2, 3 and 10 catch errors in rotation, substitution and the constant sequence.
- **All-zeros key.** Here every word depends only on the S-box and the round constants, so a wrong constant or a wrong S-box entry shows up cleanly.
- **All-ones key.** This separates a missing XOR with the earlier word from a correct result.
- **Incrementing byte pattern.** Round key 0 checks byte order at the port.

Directed runs cover three more cases: the exact ready cycle, reset in the middle of a generation, and key changes after completion.

// File: rtl/aesKsPkg.sv
package aesKsPkg;
  localparam int KS_KEY_W = 128;
  localparam int KS_WORD_W = 32;
  localparam int KS_NK = KS_KEY_W / KS_WORD_W;
  localparam int KS_NR = 10;
  localparam int KS_NW = KS_NK * (KS_NR + 1);
  localparam int KS_CW = $clog2(KS_NW + 1);
  localparam int KS_IW = $clog2(KS_NR + 2);
  localparam logic [KS_CW-1:0] KS_CNT_START = KS_CW'(KS_NK);
  localparam logic [KS_CW-1:0] KS_CNT_END = KS_CW'(KS_NW);

  typedef struct packed {
    logic loadKey;
    logic genWord;
    logic [KS_CW-1:0] wrIdx;
  } ksStrobe_t;

  function automatic logic [7:0] xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gfMul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = xtime(sh);
    end
    return acc;
  endfunction

  // multiplicative inverse as a^254, then the affine map
  function automatic logic [7:0] sbox(input logic [7:0] a);
    logic [7:0] sq;
    logic [7:0] inv;
    logic [7:0] o;
    sq = gfMul(a, a);
    inv = sq;
    for (int k = 0; k < 6; k++) begin
      sq = gfMul(sq, sq);
      inv = gfMul(inv, sq);
    end
    for (int i = 0; i < 8; i++) begin
      o[i] = inv[i] ^ inv[(i + 4) % 8] ^ inv[(i + 5) % 8] ^
             inv[(i + 6) % 8] ^ inv[(i + 7) % 8];
    end
    return o ^ 8'h63;
  endfunction

  function automatic logic [31:0] subWord(input logic [31:0] w);
    return {sbox(w[31:24]), sbox(w[23:16]), sbox(w[15:8]), sbox(w[7:0])};
  endfunction
endpackage

// File: rtl/aesKsCtrl.sv
module aesKsCtrl
  import aesKsPkg::*;
(
  input  logic      clk,
  input  logic      rst,
  output ksStrobe_t strb,
  output logic      keyReady
);
  logic [KS_CW-1:0] wordCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      wordCnt  <= KS_CNT_START;
      keyReady <= 1'b0;
    end else if (wordCnt < KS_CNT_END) begin
      wordCnt <= wordCnt + 1'b1;
      if (wordCnt == KS_CNT_END - 1'b1) keyReady <= 1'b1;
    end
  end

  always_comb begin
    strb.loadKey = rst;
    strb.genWord = !rst && (wordCnt < KS_CNT_END);
    strb.wrIdx   = wordCnt;
  end

  AST_READY_CLEARS: assert property (@(posedge clk) rst |=> !keyReady); // R4
  AST_READY_STICKY: assert property (@(posedge clk) disable iff (rst)
    keyReady |=> keyReady); // R3
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    wordCnt <= KS_CNT_END); // R2
  AST_ONE_WORD_STEP: assert property (@(posedge clk) disable iff (rst)
    strb.genWord |=> wordCnt == $past(wordCnt) + 1'b1); // R2
  AST_DONE_MEANS_READY: assert property (@(posedge clk) disable iff (rst)
    (wordCnt == KS_CNT_END) |-> keyReady); // R2
endmodule

// File: rtl/aesKsData.sv
module aesKsData
  import aesKsPkg::*;
(
  input  logic                clk,
  input  ksStrobe_t           strb,
  input  logic [KS_KEY_W-1:0] keyIn,
  input  logic [KS_IW-1:0]    rdIdx,
  output logic [KS_KEY_W-1:0] rdKey
);
  logic [KS_WORD_W-1:0] bank [KS_NW];
  logic [7:0]           rcon;
  logic [KS_WORD_W-1:0] prevWord, backWord, rotWord, newWord;
  logic                 leadWord;
  logic [KS_CW-1:0]     rdBase;

  always_comb begin
    prevWord = bank[strb.wrIdx - 1'b1];
    backWord = bank[strb.wrIdx - KS_CNT_START];
    leadWord = (strb.wrIdx[1:0] == 2'b00);
    rotWord  = {prevWord[23:0], prevWord[31:24]};
    if (leadWord) newWord = backWord ^ subWord(rotWord) ^ {rcon, 24'h000000};
    else          newWord = backWord ^ prevWord;
  end

  always_ff @(posedge clk) begin
    if (strb.loadKey) begin
      for (int k = 0; k < KS_NK; k++)
        bank[k] <= keyIn[KS_KEY_W-1-KS_WORD_W*k -: KS_WORD_W];
      rcon <= 8'h01;
    end else if (strb.genWord) begin
      bank[strb.wrIdx] <= newWord;
      if (leadWord) rcon <= xtime(rcon);
    end
  end

  always_comb begin
    rdBase = KS_CW'({rdIdx, 2'b00});
    rdKey  = '0;
    if (rdIdx <= KS_IW'(KS_NR)) begin
      for (int k = 0; k < KS_NK; k++)
        rdKey[KS_KEY_W-1-KS_WORD_W*k -: KS_WORD_W] = bank[rdBase + KS_CW'(k)];
    end
  end

  AST_FIRST_WORD_LOADED: assert property (@(posedge clk)
    strb.loadKey |=> bank[0] == $past(keyIn[KS_KEY_W-1 -: KS_WORD_W])); // R1
  AST_NO_LOAD_DURING_GEN: assert property (@(posedge clk)
    !strb.loadKey |-> !(strb.genWord && strb.wrIdx < KS_CNT_START)); // R8
endmodule

// File: rtl/aesKeyExpand.sv
module aesKeyExpand
  import aesKsPkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic [127:0] keyIn,
  input  logic [3:0]   rdIdx,
  output logic [127:0] rdKey,
  output logic         keyReady
);
  ksStrobe_t strb;

  aesKsCtrl uCtrl (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .keyReady (keyReady)
  );

  aesKsData uData (
    .clk   (clk),
    .strb  (strb),
    .keyIn (keyIn),
    .rdIdx (rdIdx),
    .rdKey (rdKey)
  );
endmodule

// File: tb/tb_aesKeyExpand.sv
module tb_aesKeyExpand;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [127:0] keyIn = '0;
  logic [3:0]   rdIdx = '0;
  logic [127:0] rdKey;
  logic         keyReady;
  int errors = 0;
  int checks = 0;
  int cycles = 0;

  aesKeyExpand dut (
    .clk(clk), .rst(rst), .keyIn(keyIn), .rdIdx(rdIdx),
    .rdKey(rdKey), .keyReady(keyReady)
  );

  always #5 clk = ~clk;

  localparam logic [127:0] K_STD  = 128'h2b7e151628aed2a6abf7158809cf4f3c;
  localparam logic [127:0] K_ZERO = 128'h0;
  localparam logic [127:0] K_ONES = {128{1'b1}};
  localparam logic [127:0] K_INC  = 128'h000102030405060708090a0b0c0d0e0f;

  typedef struct packed {
    logic [127:0] key;
    logic [3:0]   idx;
    logic [127:0] exp;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{K_STD,  4'd0,  K_STD},                                  // R1
    '{K_STD,  4'd1,  128'ha0fafe1788542cb123a339392a6c7605},  // R5 R6
    '{K_STD,  4'd2,  128'hf2c295f27a96b9435935807a7359f67f},  // R6
    '{K_STD,  4'd3,  128'h3d80477d4716fe3e1e237e446d7a883b},  // R6
    '{K_STD,  4'd10, 128'hd014f9a8c9ee2589e13f0cc8b6630ca6},  // R6
    '{K_ZERO, 4'd1,  128'h62636363626363636263636362636363},  // R6
    '{K_ZERO, 4'd2,  128'h9b9898c9f9fbfbaa9b9898c9f9fbfbaa},  // R6
    '{K_ZERO, 4'd10, 128'hb4ef5bcb3e92e21123e951cf6f8f188e},  // R6
    '{K_ONES, 4'd1,  128'he8e9e9e917161616e8e9e9e917161616},  // R5
    '{K_INC,  4'd0,  K_INC}                                   // R1
  };

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic startKey(input logic [127:0] k);
    @(negedge clk);
    keyIn = k;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic readKey(input logic [3:0] i, output logic [127:0] v);
    rdIdx = i;
    #1;
    v = rdKey;
  endtask

  task automatic finishRun;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finishRun();
    end
  end

  initial begin
    logic [127:0] v;
    logic [127:0] curKey;
    repeat (3) @(negedge clk);
    chk("R4 reset state", {127'd0, keyReady}, 128'd0);

    // R2: exact ready cycle
    startKey(K_STD);
    curKey = K_STD;
    repeat (39) @(negedge clk);
    chk("R2 ready low after 39 edges", {127'd0, keyReady}, 128'd0);
    @(negedge clk);
    chk("R2 ready high after 40 edges", {127'd0, keyReady}, 128'd1);

    // vector table
    for (int n = 0; n < NV; n++) begin
      if (VECS[n].key !== curKey) begin
        startKey(VECS[n].key);
        curKey = VECS[n].key;
        repeat (40) @(negedge clk);
      end
      readKey(VECS[n].idx, v);
      chk($sformatf("R5/R6 vector %0d (R1 for idx 0)", n), v, VECS[n].exp);
    end

    // R3: ready holds
    repeat (25) @(negedge clk);
    chk("R3 ready held", {127'd0, keyReady}, 128'd1);

    // R7: out-of-range index
    readKey(4'd11, v);
    chk("R7 index 11 zero", v, 128'd0);
    readKey(4'd15, v);
    chk("R7 index 15 zero", v, 128'd0);

    // R8: key change without reset
    @(negedge clk);
    keyIn = K_STD;
    repeat (5) @(negedge clk);
    readKey(4'd0, v);
    chk("R8 round 0 unchanged", v, K_INC);
    readKey(4'd10, v);
    chk("R8 round 10 unchanged", v, 128'h13111d7fe3944a17f307a78b4d2b30c5);

    // R4: reset clears ready in next cycle
    @(negedge clk);
    keyIn = K_STD;
    rst = 1'b1;
    @(negedge clk);
    chk("R4 ready cleared", {127'd0, keyReady}, 128'd0);
    rst = 1'b0;
    repeat (12) @(negedge clk);
    // R4: restart mid-generation with a different key
    startKey(K_ZERO);
    repeat (39) @(negedge clk);
    chk("R4 restart ready low at 39", {127'd0, keyReady}, 128'd0);
    @(negedge clk);
    chk("R4 restart ready high at 40", {127'd0, keyReady}, 128'd1);
    readKey(4'd10, v);
    chk("R4 new schedule round 10", v, 128'hb4ef5bcb3e92e21123e951cf6f8f188e);
    readKey(4'd0, v);
    chk("R4 new schedule round 0", v, K_ZERO);

    finishRun();
  end
endmodule